// File: doc/BRIEF.md
# Alias-Capable Control Register Bank

This block is a bank of 32-bit control registers on a simple word-addressed bus. It is meant for analog-control settings such as PLL configuration. Part of the bank is made of aliased groups. Each group takes four consecutive word addresses. The first address is the register itself. The other three change that register in a single write: one sets bits, one clears bits and one inverts bits. Software can therefore change one field without a read-modify-write sequence that another agent could interrupt. The rest of the bank is plain registers, which have one address each and accept only whole-word stores.

Every request gets a response on the next cycle, with read data and an error flag. Requests that are misaligned or that fall outside the implemented registers are refused: they read zero, change nothing and raise the error flag. On reset every register takes a fixed default value. In the PLL groups that default also has the lock indication bit set.

Top module: `alias_regbank`

## Requirements
- R1: After reset, the aliased groups 0, 1 and 2 read 0x80013001, 0x80012000 and 0x80011006, where bit 31 is the lock bit forced to 1. Group 3 reads 0x1018101B. The plain registers read 0x00000012, 0x05F5E100, 0x00000000 and 0x00004009. `rspValid` is low while reset is held.
- R2: The word index is `addr >> 2`. A request whose `addr[1:0]` is not zero gets an error response, reads zero and leaves every register unchanged.
- R3: A write at the base address of a group (word index 4g) stores `wrData` unchanged in that group's register.
- R4: A write at base+1 (word index 4g+1) ORs `wrData` into the group's register.
- R5: A write at base+2 (word index 4g+2) clears the register bits that are 1 in `wrData`.
- R6: A write at base+3 (word index 4g+3) XORs `wrData` into the group's register.
- R7: A read from any of the four word addresses of a group returns the current contents of that group's register.
- R8: The plain registers sit at word indices 16 to 19. A write at one of these indices stores the full word in that register only and has no effect on its neighbours.
- R9: A request at word index 20 or above reads zero, ignores the write data and gets an error response.
- R10: Each request gets exactly one response, with `rspValid` high, one cycle later, and no response appears without a request. Write responses carry zero data. A read issued in the cycle after a write to the same register returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset, loads defaults |
| req | input | 1 | Request valid this cycle |
| wrEn | input | 1 | 1 = write, 0 = read |
| addr | input | 8 | Byte address of the access |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid with `rspValid` |
| rspValid | output | 1 | Response strobe, one cycle after `req` |
| rspErr | output | 1 | Error flag: misaligned or unimplemented address |

## Verification
The bench puts each alias operation on every group and then reads all four addresses of that group. A decoder that misroutes an alias would store the raw word, change the wrong group or return alias data that differs from the base. The clear and toggle steps use patterns that overlap bits already set, so treating CLR as a plain store or TOG as OR gives wrong read-back values. The lock bit is checked right after reset and again after it is cleared, which catches a default that lacks it and a bit that cannot be written. Misaligned and out-of-range writes are followed by reads of every implemented register. A design that folds those addresses onto a real register would show the change. Back-to-back write-then-read pairs show whether stale data is forwarded.

// File: rtl/alias_regbank_pkg.sv
package alias_regbank_pkg;

  localparam int REG_W = 32;

  // The encoding equals the low two bits of the word index inside a group.
  typedef enum logic [1:0] {
    OP_PLAIN = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } wrOp_e;

  // Strobes sent from control to the datapath.
  typedef struct packed {
    logic  wrStb;
    logic  rdStb;
    logic  errStb;
    wrOp_e op;
  } bankStrobe_t;

  // Reset value of a storage slot. Groups come first, then the plain registers.
  function automatic logic [REG_W-1:0] slotDefault(input int slot,
                                                   input int numGrp,
                                                   input int lockBit,
                                                   input logic [31:0] lockMask);
    logic [REG_W-1:0] v;
    case (slot)
      0:       v = 32'h0001_3001;
      1:       v = 32'h0001_2000;
      2:       v = 32'h0001_1006;
      3:       v = 32'h1018_101B;
      4:       v = 32'h0000_0012;
      5:       v = 32'h05F5_E100;
      6:       v = 32'h0000_0000;
      7:       v = 32'h0000_4009;
      default: v = REG_W'(slot) << 8;
    endcase
    if (slot < numGrp && slot < 32) begin
      if (lockMask[slot]) v[lockBit] = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/alias_regbank_ctrl.sv
module alias_regbank_ctrl
  import alias_regbank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_GRP   = 4,
  parameter int NUM_PLAIN = 4,
  localparam int IDX_W       = ADDR_W - 2,
  localparam int NUM_SLOTS   = NUM_GRP + NUM_PLAIN,
  localparam int SLOT_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int ALIAS_WORDS = NUM_GRP * 4,
  localparam int IMPL_WORDS  = ALIAS_WORDS + NUM_PLAIN
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output bankStrobe_t       strb,
  output logic [SLOT_W-1:0] slotSel,
  output logic              rspValid,
  output logic              rspErr
);

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             inAlias;
  logic             inPlain;
  logic             legal;
  int               slotCalc;

  always_comb begin
    wordIdx  = addr[ADDR_W-1:2];
    aligned  = (addr[1:0] == 2'b00);
    inAlias  = (int'(wordIdx) < ALIAS_WORDS);
    inPlain  = !inAlias && (int'(wordIdx) < IMPL_WORDS);
    legal    = aligned && (inAlias || inPlain);
    if (inAlias) slotCalc = int'(wordIdx) / 4;
    else         slotCalc = int'(wordIdx) - ALIAS_WORDS + NUM_GRP;
    slotSel  = SLOT_W'(slotCalc);

    strb.op     = inAlias ? wrOp_e'(wordIdx[1:0]) : OP_PLAIN;
    strb.wrStb  = req && legal && wrEn;
    strb.rdStb  = req && legal && !wrEn;
    strb.errStb = req && !legal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      rspValid <= req;
      rspErr   <= strb.errStb;
    end
  end

  // R10: a request is always answered on the next cycle
  a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    req |=> rspValid);

  // R10: no response appears without a request
  a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !req |=> !rspValid);

  // R2: a misaligned access is refused
  a_r2_misaligned_err: assert property (@(posedge clk) disable iff (!rstN)
    (req && addr[1:0] != 2'b00) |=> rspErr);

  // R9: an index beyond the bank is refused
  a_r9_range_err: assert property (@(posedge clk) disable iff (!rstN)
    (req && int'(addr[ADDR_W-1:2]) >= IMPL_WORDS) |=> rspErr);

endmodule

// File: rtl/alias_regbank_dp.sv
module alias_regbank_dp
  import alias_regbank_pkg::*;
#(
  parameter int          NUM_GRP   = 4,
  parameter int          NUM_PLAIN = 4,
  parameter int          LOCK_BIT  = 31,
  parameter logic [31:0] LOCK_MASK = 32'h0000_0007,
  localparam int NUM_SLOTS = NUM_GRP + NUM_PLAIN,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobe_t       strb,
  input  logic [SLOT_W-1:0] slotSel,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData
);

  logic [NUM_SLOTS-1:0][REG_W-1:0] regQ;
  logic [REG_W-1:0]                curVal;
  logic [REG_W-1:0]                nextVal;

  // One shared modify unit serves every slot.
  always_comb begin
    curVal = (int'(slotSel) < NUM_SLOTS) ? regQ[slotSel] : '0;
    unique case (strb.op)
      OP_SET:  nextVal = curVal | wrData;
      OP_CLR:  nextVal = curVal & ~wrData;
      OP_TOG:  nextVal = curVal ^ wrData;
      default: nextVal = wrData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        regQ[s] <= slotDefault(s, NUM_GRP, LOCK_BIT, LOCK_MASK);
    end else if (strb.wrStb) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (SLOT_W'(s) == slotSel) regQ[s] <= nextVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strb.rdStb ? curVal : '0;
  end

  // R3: a plain store lands unchanged
  a_r3_plain_store: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && strb.op == OP_PLAIN) |=> regQ[$past(slotSel)] == $past(wrData));

  // R4: after a set, every bit of the data is 1 in the register
  a_r4_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && strb.op == OP_SET) |=>
      (regQ[$past(slotSel)] & $past(wrData)) == $past(wrData));

  // R5: after a clear, every bit of the data is 0 in the register
  a_r5_clr_bits: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && strb.op == OP_CLR) |=>
      (regQ[$past(slotSel)] & $past(wrData)) == '0);

  // R6: a toggle inverts exactly the bits in the data
  a_r6_tog_bits: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStb && strb.op == OP_TOG) |=>
      (regQ[$past(slotSel)] ^ $past(curVal)) == $past(wrData));

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlotChk
    // R9: a slot that is not written keeps its value
    a_r9_slot_stable: assert property (@(posedge clk) disable iff (!rstN)
      !(strb.wrStb && slotSel == SLOT_W'(g)) |=> $stable(regQ[g]));
    if (g < NUM_GRP && g < 32) begin : gLock
      if (LOCK_MASK[g]) begin : gOn
        // R1: a PLL group leaves reset with the lock bit set
        a_r1_lock_default: assert property (@(posedge clk) disable iff (!rstN)
          $rose(rstN) |-> regQ[g][LOCK_BIT]);
      end
    end
  end

endmodule

// File: rtl/alias_regbank.sv
module alias_regbank
  import alias_regbank_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          NUM_GRP   = 4,
  parameter int          NUM_PLAIN = 4,
  parameter int          LOCK_BIT  = 31,
  parameter logic [31:0] LOCK_MASK = 32'h0000_0007,
  localparam int NUM_SLOTS = NUM_GRP + NUM_PLAIN,
  localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              req,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  output logic              rspValid,
  output logic              rspErr
);

  bankStrobe_t       strb;
  logic [SLOT_W-1:0] slotSel;

  alias_regbank_ctrl #(
    .ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP), .NUM_PLAIN(NUM_PLAIN)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .req(req), .wrEn(wrEn), .addr(addr),
    .strb(strb), .slotSel(slotSel), .rspValid(rspValid), .rspErr(rspErr)
  );

  alias_regbank_dp #(
    .NUM_GRP(NUM_GRP), .NUM_PLAIN(NUM_PLAIN),
    .LOCK_BIT(LOCK_BIT), .LOCK_MASK(LOCK_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .slotSel(slotSel),
    .wrData(wrData), .rdData(rdData)
  );

  // R9: a refused access returns zero data
  a_r9_err_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rdData == '0);

  // R10: the error flag only appears with a response
  a_r10_err_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);

endmodule

// File: tb/alias_regbank_tb.sv
`timescale 1ns/1ps
module alias_regbank_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        rspValid;
  logic        rspErr;

  int checks = 0;
  int errors = 0;
  logic [31:0] refMem [8];

  logic [31:0] expDataQ[$];
  logic        expErrQ[$];
  string       tagQ[$];

  always #5 clk = ~clk;

  alias_regbank u_dut (
    .clk(clk), .rstN(rstN), .req(req), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rspValid(rspValid), .rspErr(rspErr)
  );

  // Storage slot of a byte address, -1 when refused (R2, R9)
  function automatic int slotOf(input logic [7:0] a);
    int w;
    w = int'(a) / 4;
    if (a[1:0] != 2'b00) return -1;
    if (w < 16) return w / 4;
    if (w < 20) return w - 12;
    return -1;
  endfunction

  task automatic doAccess(input logic w, input logic [7:0] a,
                          input logic [31:0] d, input string tag);
    int s;
    logic [31:0] expD;
    @(negedge clk);
    req = 1'b1; wrEn = w; addr = a; wrData = d;
    s = slotOf(a);
    expD = '0;
    if (s >= 0) begin
      if (w) begin
        if (int'(a) < 64) begin
          case (a[3:2])
            2'd1:    refMem[s] = refMem[s] | d;
            2'd2:    refMem[s] = refMem[s] & ~d;
            2'd3:    refMem[s] = refMem[s] ^ d;
            default: refMem[s] = d;
          endcase
        end else begin
          refMem[s] = d;
        end
      end else begin
        expD = refMem[s];
      end
    end
    expDataQ.push_back(expD);
    expErrQ.push_back(s < 0);
    tagQ.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req = 1'b0; wrEn = 1'b0;
    end
  endtask

  task automatic readGroup(input int g, input string tag);
    for (int k = 0; k < 4; k++) doAccess(1'b0, 8'(g * 16 + k * 4), '0, tag);
  endtask

  // Scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (rspValid) begin
        checks++;
        if (expDataQ.size() == 0) begin
          errors++;
          $display("FAIL R10 response without request: act valid=1 exp valid=0");
        end else begin
          logic [31:0] eD;
          logic eE;
          string t;
          eD = expDataQ.pop_front();
          eE = expErrQ.pop_front();
          t  = tagQ.pop_front();
          if (rdData !== eD || rspErr !== eE) begin
            errors++;
            $display("FAIL %s act data=%08h err=%0b exp data=%08h err=%0b",
                     t, rdData, rspErr, eD, eE);
          end
        end
      end else if (expDataQ.size() != 0) begin
        checks++;
        errors++;
        $display("FAIL R10 missing response: act valid=0 exp valid=1");
        void'(expDataQ.pop_front());
        void'(expErrQ.pop_front());
        void'(tagQ.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: act running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1 defaults, taken from the requirement
    refMem[0] = 32'h8001_3001; refMem[1] = 32'h8001_2000;
    refMem[2] = 32'h8001_1006; refMem[3] = 32'h1018_101B;
    refMem[4] = 32'h0000_0012; refMem[5] = 32'h05F5_E100;
    refMem[6] = 32'h0000_0000; refMem[7] = 32'h0000_4009;

    repeat (3) @(negedge clk);
    checks++;
    if (rspValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 rspValid in reset: act %0b exp 0", rspValid);
    end
    rstN = 1'b1;
    idle(2);

    // R1, R7, R9: read every word address after reset
    for (int w = 0; w < 64; w++) doAccess(1'b0, 8'(w * 4), '0, (w < 20) ? "R1" : "R9");
    idle(1);

    // R3..R7 on each group
    for (int g = 0; g < 4; g++) begin
      doAccess(1'b1, 8'(g * 16), 32'hA5A5_0F0F ^ 32'(g), "R3");
      readGroup(g, "R3");
      doAccess(1'b1, 8'(g * 16 + 4), 32'h0000_F0F0, "R4");
      readGroup(g, "R4");
      idle(1);
      doAccess(1'b1, 8'(g * 16 + 8), 32'hA000_00FF, "R5");
      readGroup(g, "R5");
      doAccess(1'b1, 8'(g * 16 + 12), 32'hFFFF_0330, "R6");
      readGroup(g, "R7");
      idle(2);
    end

    // R1: the lock bit is writable after reset
    doAccess(1'b1, 8'h08, 32'h8000_0000, "R5");
    doAccess(1'b0, 8'h00, '0, "R5");

    // R8: plain registers store whole words, neighbours untouched
    for (int p = 0; p < 4; p++) doAccess(1'b1, 8'(64 + p * 4), 32'h1234_0000 | 32'(p * 3), "R8");
    doAccess(1'b1, 8'h44, 32'hFFFF_FFFF, "R8");
    for (int p = 0; p < 4; p++) doAccess(1'b0, 8'(64 + p * 4), '0, "R8");
    idle(1);

    // R2: misaligned accesses are refused
    doAccess(1'b1, 8'h01, 32'hFFFF_FFFF, "R2");
    doAccess(1'b1, 8'h46, 32'hFFFF_FFFF, "R2");
    doAccess(1'b0, 8'h02, '0, "R2");
    doAccess(1'b0, 8'h00, '0, "R2");
    doAccess(1'b0, 8'h44, '0, "R2");

    // R9: out-of-range writes change nothing
    doAccess(1'b1, 8'h50, 32'hDEAD_BEEF, "R9");
    doAccess(1'b1, 8'hFC, 32'hDEAD_BEEF, "R9");
    doAccess(1'b0, 8'h50, '0, "R9");
    for (int w = 0; w < 20; w++) doAccess(1'b0, 8'(w * 4), '0, "R9");
    idle(1);

    // R10: write then read of the same register on back-to-back cycles
    doAccess(1'b1, 8'h10, 32'h0F0F_0F0F, "R10");
    doAccess(1'b0, 8'h10, '0, "R10");
    doAccess(1'b1, 8'h1C, 32'h00FF_00FF, "R10");
    doAccess(1'b0, 8'h14, '0, "R10");
    doAccess(1'b1, 8'h4C, 32'h7777_7777, "R10");
    doAccess(1'b0, 8'h4C, '0, "R10");
    idle(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule